// File: doc/BRIEF.md
# Span Card Control Register Block

This block is the card-level register file inside the glue FPGA of a four-span T1 line card. It sits on a byte-wide local bus behind the host bridge. The bus window is split into two regions. The low part holds four 256-byte windows, one for each framer transceiver; an access there is forwarded as a one-hot chip-select. Four card registers sit just above that region. They set the timing reference, the interrupt policy, the loopback paths, the span LEDs and two test pins.

The card interrupt is a latched flag. Two sources can set it: a frame tick from the buffer logic, and a rising edge on the framer interrupt line. Each source has its own enable. Software clears the flag by writing a one to a self-clearing acknowledge bit in the control register. The interrupt pin shows the flag only while the main interrupt enable is set. All outputs come from flops.

Top module: `span_card_regs`

## Requirements
- R1: Reset is synchronous and active high. It clears every output: sync_src, led, test pins, loopback selects, card_irq, framer_cs and bus_rdata all read zero.
- R2: A write to offset 0x400 sets sync_src from wdata[2:0] on the next cycle. Codes 1..4 pick the recovered clock of span 1..4, and 0 means free-run. Codes 5..7 are stored as 0, and wdata[7:3] is ignored.
- R3: A write to offset 0x401 stores the control bits. Bit 0 is the interrupt enable, bit 1 drives test1_o and bit 2 is the framer-interrupt enable. Bit 5 drives remote_lpbk (transmit serial taken from received serial) and bit 6 drives local_lpbk (receive buffers fed from transmit buffers).
- R4: Writing a 1 to control bit 7 clears the pending flag. The bit itself is not stored.
- R5: A write to offset 0x402 loads led. Bit 2n lights the green LED of span n+1 and bit 2n+1 lights its red LED; both on together show yellow. led changes only on such a write.
- R6: A write to offset 0x403 drives test2_o from wdata[0]. Bits 7:1 are ignored.
- R7: A read strobe at offset 0x400 returns status on bus_rdata one cycle later. Bit 0 is the interrupt enable, bit 1 is the pending flag and bit 2 is the sampled framer interrupt level; all other bits are 0. Any other read returns 0.
- R8: A frame_tick pulse sets the pending flag only while the interrupt enable is 1.
- R9: A 0-to-1 edge of framer_irq sets the pending flag only while the framer-interrupt enable is 1. A level that stays high does not set the flag again after an acknowledge.
- R10: card_irq is high exactly when the pending flag and the interrupt enable are both 1. Clearing the enable masks the pin but keeps the flag.
- R11: If an acknowledge and a setting event arrive in the same cycle, the flag stays set.
- R12: A read or write below 0x400 pulses framer_cs bit addr[9:8] for one cycle, one cycle after the access. Accesses at 0x400 and above assert no chip-select.
- R13: Writes to offsets 0x404..0x7FF change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 11 | Byte offset in the register window |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per access |
| bus_re | input | 1 | Read strobe, one cycle per access |
| bus_rdata | output | 8 | Read data, valid the cycle after bus_re |
| framer_irq | input | 1 | Interrupt line from the framer |
| frame_tick | input | 1 | Frame event pulse from the buffer logic |
| framer_cs | output | 4 | One-hot transceiver chip-select |
| sync_src | output | 3 | Selected timing reference |
| remote_lpbk | output | 1 | Remote serial loopback select |
| local_lpbk | output | 1 | Local buffer loopback select |
| test1_o | output | 1 | Test pin 1 |
| test2_o | output | 1 | Test pin 2 |
| led | output | 8 | Bicolour span LED drive |
| card_irq | output | 1 | Card interrupt |

## Verification
A flag that is wrongly latched or wrongly cleared shows up on card_irq in the cycle after the event or the acknowledge. The next status read then shows it in bit 1. A wrong edge detector on the framer line is exposed by holding that line high across an acknowledge: the flag must stay clear. A decode error shows up one cycle after the access, either as a wrong chip-select bit or as an output that changed when it should not have. The bench watches each output after every write so that these faults are seen in the cycle they occur.

// File: rtl/span_card_pkg.sv
package span_card_pkg;
  // card register offsets relative to the end of the framer windows
  localparam int unsigned OFS_SYNC  = 0;
  localparam int unsigned OFS_CTL   = 1;
  localparam int unsigned OFS_LED   = 2;
  localparam int unsigned OFS_TEST2 = 3;

  // control register bit positions
  localparam int unsigned CB_IE    = 0;
  localparam int unsigned CB_TEST1 = 1;
  localparam int unsigned CB_FIE   = 2;
  localparam int unsigned CB_RLB   = 5;
  localparam int unsigned CB_LLB   = 6;
  localparam int unsigned CB_ACK   = 7;

  // status bit positions
  localparam int unsigned SB_IE   = 0;
  localparam int unsigned SB_PEND = 1;
  localparam int unsigned SB_FRM  = 2;

  typedef struct packed {
    logic wr_sync;
    logic wr_ctl;
    logic wr_led;
    logic wr_test2;
    logic rd_stat;
  } card_strb_t;
endpackage

// File: rtl/span_card_decode.sv
module span_card_decode
  import span_card_pkg::*;
#(
  parameter int ADDR_W    = 11,
  parameter int WIN_W     = 8,
  parameter int NUM_SPANS = 4
) (
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 we,
  input  logic                 re,
  output card_strb_t           strb,
  output logic [NUM_SPANS-1:0] cs_d
);
  localparam int SEL_W = (NUM_SPANS > 1) ? $clog2(NUM_SPANS) : 1;
  localparam logic [ADDR_W-1:0] CARD_BASE = ADDR_W'(NUM_SPANS << WIN_W);

  logic in_framer;
  assign in_framer = (addr < CARD_BASE);

  always_comb begin
    strb          = '0;
    strb.wr_sync  = we && (addr == CARD_BASE + ADDR_W'(OFS_SYNC));
    strb.wr_ctl   = we && (addr == CARD_BASE + ADDR_W'(OFS_CTL));
    strb.wr_led   = we && (addr == CARD_BASE + ADDR_W'(OFS_LED));
    strb.wr_test2 = we && (addr == CARD_BASE + ADDR_W'(OFS_TEST2));
    strb.rd_stat  = re && (addr == CARD_BASE + ADDR_W'(OFS_SYNC));
  end

  for (genvar i = 0; i < NUM_SPANS; i++) begin : g_cs
    assign cs_d[i] = (we || re) && in_framer && (addr[WIN_W +: SEL_W] == SEL_W'(i));
  end
endmodule

// File: rtl/span_card_irq.sv
module span_card_irq (
  input  logic clk,
  input  logic rst,
  input  logic ie_q,
  input  logic ie_d,
  input  logic fie_q,
  input  logic frame_tick,
  input  logic framer_irq,
  input  logic ack,
  output logic flag_q,
  output logic frm_lvl_q,
  output logic card_irq
);
  logic rise, set_evt, flag_d;

  assign rise    = framer_irq && !frm_lvl_q;
  assign set_evt = (frame_tick && ie_q) || (rise && fie_q);
  // a fresh event beats a simultaneous acknowledge
  assign flag_d  = set_evt || (flag_q && !ack);

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q    <= 1'b0;
      frm_lvl_q <= 1'b0;
      card_irq  <= 1'b0;
    end else begin
      flag_q    <= flag_d;
      frm_lvl_q <= framer_irq;
      card_irq  <= flag_d && ie_d;
    end
  end

  // R8 R9 R11
  set_wins_chk: assert property (@(posedge clk) disable iff (rst) set_evt |=> flag_q);
  // R4
  ack_clears_chk: assert property (@(posedge clk) disable iff (rst) (ack && !set_evt) |=> !flag_q);
  // R10
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (rst) card_irq |-> flag_q);
endmodule

// File: rtl/span_card_bank.sv
module span_card_bank
  import span_card_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int NUM_SPANS = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  card_strb_t             strb,
  input  logic [DATA_W-1:0]      wdata,
  input  logic                   flag_q,
  input  logic                   frm_lvl_q,
  output logic                   ie_q,
  output logic                   ie_d,
  output logic                   fie_q,
  output logic                   test1_o,
  output logic                   test2_o,
  output logic                   remote_lpbk,
  output logic                   local_lpbk,
  output logic [2*NUM_SPANS-1:0] led,
  output logic [$clog2(NUM_SPANS+1)-1:0] sync_src,
  output logic [DATA_W-1:0]      rdata
);
  localparam int SYNC_W = $clog2(NUM_SPANS + 1);
  localparam int LED_W  = 2 * NUM_SPANS;

  logic [SYNC_W-1:0] sync_req;
  logic [DATA_W-1:0] stat;

  assign sync_req = wdata[SYNC_W-1:0];
  assign ie_d     = strb.wr_ctl ? wdata[CB_IE] : ie_q;

  always_comb begin
    stat          = '0;
    stat[SB_IE]   = ie_q;
    stat[SB_PEND] = flag_q;
    stat[SB_FRM]  = frm_lvl_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ie_q        <= 1'b0;
      fie_q       <= 1'b0;
      test1_o     <= 1'b0;
      test2_o     <= 1'b0;
      remote_lpbk <= 1'b0;
      local_lpbk  <= 1'b0;
      led         <= '0;
      sync_src    <= '0;
      rdata       <= '0;
    end else begin
      if (strb.wr_sync)
        sync_src <= (sync_req > SYNC_W'(NUM_SPANS)) ? '0 : sync_req;
      if (strb.wr_ctl) begin
        ie_q        <= wdata[CB_IE];
        test1_o     <= wdata[CB_TEST1];
        fie_q       <= wdata[CB_FIE];
        remote_lpbk <= wdata[CB_RLB];
        local_lpbk  <= wdata[CB_LLB];
      end
      if (strb.wr_led)
        led <= wdata[LED_W-1:0];
      if (strb.wr_test2)
        test2_o <= wdata[0];
      rdata <= strb.rd_stat ? stat : '0;
    end
  end

  // R2
  sync_range_chk: assert property (@(posedge clk) disable iff (rst) sync_src <= SYNC_W'(NUM_SPANS));
  // R5
  led_hold_chk: assert property (@(posedge clk) disable iff (rst) !strb.wr_led |=> $stable(led));
endmodule

// File: rtl/span_card_regs.sv
module span_card_regs
  import span_card_pkg::*;
#(
  parameter int ADDR_W    = 11,
  parameter int DATA_W    = 8,
  parameter int WIN_W     = 8,
  parameter int NUM_SPANS = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  input  logic                 bus_we,
  input  logic                 bus_re,
  output logic [DATA_W-1:0]    bus_rdata,
  input  logic                 framer_irq,
  input  logic                 frame_tick,
  output logic [NUM_SPANS-1:0] framer_cs,
  output logic [$clog2(NUM_SPANS+1)-1:0] sync_src,
  output logic                 remote_lpbk,
  output logic                 local_lpbk,
  output logic                 test1_o,
  output logic                 test2_o,
  output logic [2*NUM_SPANS-1:0] led,
  output logic                 card_irq
);
  card_strb_t           strb;
  logic [NUM_SPANS-1:0] cs_d;
  logic ie_q, ie_d, fie_q, flag_q, frm_lvl_q;

  span_card_decode #(.ADDR_W(ADDR_W), .WIN_W(WIN_W), .NUM_SPANS(NUM_SPANS)) u_dec (
    .addr(bus_addr), .we(bus_we), .re(bus_re), .strb(strb), .cs_d(cs_d)
  );

  span_card_irq u_irq (
    .clk(clk), .rst(rst), .ie_q(ie_q), .ie_d(ie_d), .fie_q(fie_q),
    .frame_tick(frame_tick), .framer_irq(framer_irq),
    .ack(strb.wr_ctl && bus_wdata[CB_ACK]),
    .flag_q(flag_q), .frm_lvl_q(frm_lvl_q), .card_irq(card_irq)
  );

  span_card_bank #(.DATA_W(DATA_W), .NUM_SPANS(NUM_SPANS)) u_bank (
    .clk(clk), .rst(rst), .strb(strb), .wdata(bus_wdata),
    .flag_q(flag_q), .frm_lvl_q(frm_lvl_q),
    .ie_q(ie_q), .ie_d(ie_d), .fie_q(fie_q),
    .test1_o(test1_o), .test2_o(test2_o),
    .remote_lpbk(remote_lpbk), .local_lpbk(local_lpbk),
    .led(led), .sync_src(sync_src), .rdata(bus_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) framer_cs <= '0;
    else     framer_cs <= cs_d;
  end

  // R12
  cs_onehot_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(framer_cs));
endmodule

// File: tb/test_span_card_regs.sv
module test_span_card_regs;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [10:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic        bus_we = 1'b0, bus_re = 1'b0;
  logic [7:0]  bus_rdata;
  logic        framer_irq = 1'b0, frame_tick = 1'b0;
  logic [3:0]  framer_cs;
  logic [2:0]  sync_src;
  logic        remote_lpbk, local_lpbk, test1_o, test2_o, card_irq;
  logic [7:0]  led;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  span_card_regs i_span_card_regs (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .framer_irq(framer_irq), .frame_tick(frame_tick), .framer_cs(framer_cs),
    .sync_src(sync_src), .remote_lpbk(remote_lpbk), .local_lpbk(local_lpbk),
    .test1_o(test1_o), .test2_o(test2_o), .led(led), .card_irq(card_irq)
  );

  // {sel[1:0], addr[10:0], wdata[7:0], expect[7:0]}
  // sel 0: sync_src, 1: led, 2: {remote, local, test1, test2}
  localparam int NV = 16;
  localparam logic [28:0] VEC [NV] = '{
    {2'd0, 11'h400, 8'h03, 8'h03},  // R2
    {2'd0, 11'h400, 8'h04, 8'h04},  // R2
    {2'd0, 11'h400, 8'h06, 8'h00},  // R2 out of range
    {2'd0, 11'h400, 8'hF9, 8'h01},  // R2 upper bits ignored
    {2'd0, 11'h400, 8'h05, 8'h00},  // R2
    {2'd1, 11'h402, 8'h01, 8'h01},  // R5
    {2'd1, 11'h402, 8'hAA, 8'hAA},  // R5
    {2'd1, 11'h402, 8'hFF, 8'hFF},  // R5
    {2'd1, 11'h404, 8'h00, 8'hFF},  // R13
    {2'd1, 11'h7FF, 8'h00, 8'hFF},  // R13
    {2'd2, 11'h403, 8'h01, 8'h01},  // R6
    {2'd2, 11'h403, 8'hFE, 8'h00},  // R6
    {2'd2, 11'h401, 8'h22, 8'h0A},  // R3
    {2'd2, 11'h401, 8'h40, 8'h04},  // R3
    {2'd2, 11'h405, 8'hFF, 8'h04},  // R13
    {2'd2, 11'h401, 8'h00, 8'h00}   // R3
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [10:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [10:0] a, output logic [7:0] d);
    bus_addr = a; bus_re = 1'b1;
    @(negedge clk);
    d = bus_rdata;
    bus_re = 1'b0;
  endtask

  task automatic tick();
    frame_tick = 1'b1;
    @(negedge clk);
    frame_tick = 1'b0;
  endtask

  function automatic logic [7:0] pins();
    return {4'b0, remote_lpbk, local_lpbk, test1_o, test2_o};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 sync", {5'b0, sync_src}, 8'h00);
    chk("R1 led", led, 8'h00);
    chk("R1 pins", pins(), 8'h00);
    chk("R1 irq/cs", {3'b0, card_irq, framer_cs}, 8'h00);
    chk("R1 rdata", bus_rdata, 8'h00);

    for (int i = 0; i < NV; i++) begin
      logic [7:0] act;
      wr(VEC[i][26:16], VEC[i][15:8]);
      case (VEC[i][28:27])
        2'd0:    act = {5'b0, sync_src};
        2'd1:    act = led;
        default: act = pins();
      endcase
      chk($sformatf("R2/R3/R5/R6/R13 vec%0d", i), act, VEC[i][7:0]);
    end

    // R8 tick ignored while disabled
    tick();
    rd(11'h400, r);
    chk("R8 masked tick", r, 8'h00);
    wr(11'h401, 8'h01);
    tick();
    chk("R8 R10 irq after tick", {7'b0, card_irq}, 8'h01);
    rd(11'h400, r);
    chk("R7 status pending", r, 8'h03);
    // R4 acknowledge
    wr(11'h401, 8'h81);
    chk("R4 irq cleared", {7'b0, card_irq}, 8'h00);
    rd(11'h400, r);
    chk("R4 ack not stored", r, 8'h01);
    // R10 mask keeps flag
    tick();
    wr(11'h401, 8'h00);
    chk("R10 masked pin", {7'b0, card_irq}, 8'h00);
    rd(11'h400, r);
    chk("R10 flag kept", r, 8'h02);
    wr(11'h401, 8'h01);
    chk("R10 unmask", {7'b0, card_irq}, 8'h01);
    // R11 ack with simultaneous tick
    frame_tick = 1'b1;
    wr(11'h401, 8'h81);
    frame_tick = 1'b0;
    chk("R11 event wins", {7'b0, card_irq}, 8'h01);
    wr(11'h401, 8'h81);
    chk("R11 later ack", {7'b0, card_irq}, 8'h00);
    // R9 framer edge
    wr(11'h401, 8'h05);
    framer_irq = 1'b1;
    @(negedge clk);
    chk("R9 framer edge", {7'b0, card_irq}, 8'h01);
    rd(11'h400, r);
    chk("R7 R9 status", r, 8'h07);
    wr(11'h401, 8'h85);
    @(negedge clk);
    rd(11'h400, r);
    chk("R9 level no re-set", r, 8'h05);
    framer_irq = 1'b0;
    wr(11'h401, 8'h01);
    framer_irq = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rd(11'h400, r);
    chk("R9 framer disabled", {r[7:1], card_irq}, 8'h04);
    framer_irq = 1'b0;
    // R12 chip-selects
    rd(11'h2A5, r);
    chk("R12 cs span3", {4'b0, framer_cs}, 8'h04);
    chk("R7 framer read data", r, 8'h00);
    @(negedge clk);
    chk("R12 cs pulse ends", {4'b0, framer_cs}, 8'h00);
    wr(11'h010, 8'h55);
    chk("R12 cs span1", {4'b0, framer_cs}, 8'h01);
    wr(11'h3FF, 8'h55);
    chk("R12 cs span4", {4'b0, framer_cs}, 8'h08);
    rd(11'h400, r);
    chk("R12 no cs on card reg", {4'b0, framer_cs}, 8'h00);
    // R1 reset mid-run
    wr(11'h402, 8'h3C);
    wr(11'h401, 8'h63);
    tick();
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1 led after reset", led, 8'h00);
    chk("R1 pins after reset", {3'b0, card_irq, pins()}, 8'h00);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule